// File: doc/BRIEF.md
# CAN Control-Field Reserved-Bit Form Checker

This block watches an incoming CAN or CAN FD frame one destuffed bit at a time. It starts at the first identifier bit and stops once the control-field reserved bits have passed. It reads the identifier-extension bit and the FD-format bit as they go by. From these two values it works out where the reserved bits sit for the current frame layout. A reserved bit must be sampled dominant. If one is sampled recessive, the block flags a form error and raises a request for an error frame. The request stays up until the frame is declared finished.

The block also holds an error-capture register made of two codes: an error type and the frame field in which the error was found. The first form error of a frame loads the register. A software clear strobe returns it to its idle value. Surrounding logic supplies three strobes: one marking the start of arbitration, one per sampled bit (with a flag for stuff bits), and one marking the end of the frame. A static input tells the block whether the node accepts FD frames.

Top module: `can_ctrl_form_chk`

## Requirements
- R1: After reset, err_req is 0, cap_type is 3'b000 (none) and cap_pos is 4'd15 (other).
- R2: With fd_en = 0 and IDE (offset 12) dominant, a recessive bit at offset 13 (r0 of a classic base frame) is a form error. One cycle later err_req is 1, cap_type is 3'b010 (form) and cap_pos is 4'd3 (control field). Offsets count non-stuff bits from 0 at the first bit after arb_start.
- R3: With fd_en = 1 and IDE dominant, offset 13 is the FD-format bit. If it is recessive, a recessive bit at offset 14 is a form error. If it is dominant, offset 14 is not checked.
- R4: With fd_en = 0 and IDE recessive, a recessive bit at offset 32 (r1) or at offset 33 (r0) is a form error.
- R5: With fd_en = 1 and IDE recessive, offset 32 is the FD-format bit and is never an error. A recessive bit at offset 33 (r0) is a form error.
- R6: A strobe with stuff_bit = 1 never causes an error and does not advance the bit offset.
- R7: A recessive bit at any offset other than the reserved positions in R2 to R5 never causes an error.
- R8: Once err_req is 1, it stays 1, including across a new arb_start, until a frame_end strobe. The cycle after frame_end, err_req is 0.
- R9: Only the first form error after an arb_start loads the capture register. A later error in the same frame leaves it unchanged, even if it was cleared in between.
- R10: sw_clear sets cap_type to 3'b000 and cap_pos to 4'd15. If a first form error arrives in the same cycle, the error capture takes priority.
- R11: Bit strobes after frame_end and before the next arb_start are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fd_en | input | 1 | 1: node accepts FD frames, so the bit after IDE (base) or after RTR (extended) is the FD-format bit |
| arb_start | input | 1 | Strobe: the next non-stuff bit is offset 0 |
| bit_vld | input | 1 | Sample-point strobe for bit_val |
| bit_val | input | 1 | Sampled bus level, 1 = recessive |
| stuff_bit | input | 1 | The current strobe is a stuff bit |
| frame_end | input | 1 | Strobe: frame over; stops tracking and drops err_req |
| sw_clear | input | 1 | Software clear of the capture register |
| err_req | output | 1 | Error frame request |
| cap_type | output | 3 | Captured error type: 000 none, 010 form |
| cap_pos | output | 4 | Captured error position: 3 control, 15 other |

## Verification
Every strobe is registered at one rising edge, so its effect appears on err_req, cap_type and cap_pos right after that edge. No output changes later than that. The bench changes inputs at a falling edge and holds each strobe for exactly one cycle. It reads the outputs at the next falling edge, which is the one-cycle point for every result. Random frames are scored by a bench model of the reserved-bit positions. Directed frames cover the ordering cases: a stuff strobe placed ahead of a reserved bit, a clear between two errors, a clear in the same cycle as an error, and strobes outside a frame.

// File: rtl/can_cfc_pkg.sv
package can_cfc_pkg;

    // Bit offsets from the first identifier bit (stuff bits excluded)
    localparam int unsigned OFS_IDE      = 12;
    localparam int unsigned OFS_BASE_FDF = 13;
    localparam int unsigned OFS_BASE_R0  = 14;
    localparam int unsigned OFS_EXT_R1   = 32;
    localparam int unsigned OFS_EXT_R0   = 33;
    localparam int unsigned OFS_LAST     = OFS_EXT_R0;

    localparam int unsigned TYPE_W = 3;
    localparam int unsigned POS_W  = 4;

    typedef enum logic [TYPE_W-1:0] {
        ET_NONE = 3'b000,
        ET_FORM = 3'b010
    } err_type_e;

    typedef enum logic [POS_W-1:0] {
        EP_CTRL  = 4'd3,
        EP_OTHER = 4'd15
    } err_pos_e;

    typedef struct packed {
        logic ide;
        logic fdf;
    } layout_st_t;

    typedef struct packed {
        logic      req;
        logic      seen;
        err_type_e typ;
        err_pos_e  pos;
    } cap_st_t;

endpackage

// File: rtl/can_cfc_ofs.sv
module can_cfc_ofs #(
    parameter int unsigned LAST = can_cfc_pkg::OFS_LAST,
    localparam int unsigned W   = $clog2(LAST + 2)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         arb_start,
    input  logic         frame_end,
    input  logic         bit_vld,
    input  logic         stuff_bit,
    output logic         take,
    output logic [W-1:0] ofs
);

    typedef struct packed {
        logic         act;
        logic [W-1:0] cnt;
    } ofs_st_t;

    ofs_st_t s_q, s_d;

    always_comb begin
        take = bit_vld & ~stuff_bit & s_q.act & ~arb_start & ~frame_end;
        s_d  = s_q;
        if (frame_end) begin
            s_d.act = 1'b0;
        end else if (arb_start) begin
            s_d.act = 1'b1;
            s_d.cnt = '0;
        end else if (take) begin
            if (s_q.cnt == W'(LAST)) begin
                s_d.act = 1'b0;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ofs = s_q.cnt;

endmodule

// File: rtl/can_cfc_layout.sv
module can_cfc_layout
    import can_cfc_pkg::*;
#(
    parameter int unsigned W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         arb_start,
    input  logic         take,
    input  logic [W-1:0] ofs,
    input  logic         bit_val,
    input  logic         fd_en,
    output logic         form_err
);

    layout_st_t s_q, s_d;
    logic       rsv;

    always_comb begin
        s_d = s_q;
        rsv = 1'b0;
        if (arb_start) begin
            s_d = '0;
        end
        if (ofs == W'(OFS_IDE) && take) begin
            s_d.ide = bit_val;
        end
        if (!s_q.ide) begin
            if (ofs == W'(OFS_BASE_FDF)) begin
                if (fd_en) begin
                    if (take) s_d.fdf = bit_val;
                end else begin
                    rsv = 1'b1;
                end
            end
            if (ofs == W'(OFS_BASE_R0) && s_q.fdf) begin
                rsv = 1'b1;
            end
        end else begin
            if (ofs == W'(OFS_EXT_R1)) begin
                if (fd_en) begin
                    if (take) s_d.fdf = bit_val;
                end else begin
                    rsv = 1'b1;
                end
            end
            if (ofs == W'(OFS_EXT_R0)) begin
                rsv = 1'b1;
            end
        end
        form_err = take & rsv & bit_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/can_cfc_capture.sv
module can_cfc_capture
    import can_cfc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arb_start,
    input  logic              frame_end,
    input  logic              sw_clear,
    input  logic              form_err,
    output logic              err_req,
    output logic [TYPE_W-1:0] cap_type,
    output logic [POS_W-1:0]  cap_pos
);

    cap_st_t s_q, s_d;

    always_comb begin
        s_d = s_q;
        if (arb_start) begin
            s_d.seen = 1'b0;
        end
        if (frame_end) begin
            s_d.req = 1'b0;
        end
        if (sw_clear) begin
            s_d.typ = ET_NONE;
            s_d.pos = EP_OTHER;
        end
        if (form_err) begin
            s_d.req = 1'b1;
            if (!s_q.seen) begin
                s_d.typ  = ET_FORM;
                s_d.pos  = EP_CTRL;
                s_d.seen = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{req: 1'b0, seen: 1'b0, typ: ET_NONE, pos: EP_OTHER};
        end else begin
            s_q <= s_d;
        end
    end

    assign err_req  = s_q.req;
    assign cap_type = s_q.typ;
    assign cap_pos  = s_q.pos;

endmodule

// File: rtl/can_ctrl_form_chk.sv
module can_ctrl_form_chk
    import can_cfc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fd_en,
    input  logic              arb_start,
    input  logic              bit_vld,
    input  logic              bit_val,
    input  logic              stuff_bit,
    input  logic              frame_end,
    input  logic              sw_clear,
    output logic              err_req,
    output logic [TYPE_W-1:0] cap_type,
    output logic [POS_W-1:0]  cap_pos
);

    localparam int unsigned OW = $clog2(OFS_LAST + 2);

    logic          take;
    logic [OW-1:0] ofs;
    logic          frm_err;

    can_cfc_ofs #(.LAST(OFS_LAST)) u_ofs (
        .clk       (clk),
        .rst_n     (rst_n),
        .arb_start (arb_start),
        .frame_end (frame_end),
        .bit_vld   (bit_vld),
        .stuff_bit (stuff_bit),
        .take      (take),
        .ofs       (ofs)
    );

    can_cfc_layout #(.W(OW)) u_layout (
        .clk       (clk),
        .rst_n     (rst_n),
        .arb_start (arb_start),
        .take      (take),
        .ofs       (ofs),
        .bit_val   (bit_val),
        .fd_en     (fd_en),
        .form_err  (frm_err)
    );

    can_cfc_capture u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .arb_start (arb_start),
        .frame_end (frame_end),
        .sw_clear  (sw_clear),
        .form_err  (frm_err),
        .err_req   (err_req),
        .cap_type  (cap_type),
        .cap_pos   (cap_pos)
    );

endmodule

// File: rtl/can_cfc_chk.sv
module can_cfc_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       stuff_bit,
    input logic       frame_end,
    input logic       sw_clear,
    input logic       form_err,
    input logic       err_req,
    input logic [2:0] cap_type,
    input logic [3:0] cap_pos
);

    a_r1_type_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_type == 3'b000) || (cap_type == 3'b010));

    a_r2_err_frame_req: assert property (@(posedge clk) disable iff (!rst_n)
        form_err |=> err_req);

    a_r6_stuff_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        stuff_bit |-> !form_err);

    a_r8_req_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (err_req && !frame_end) |=> err_req);

    a_r8_req_drops: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> !err_req);

    a_r9_pos_needs_error: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_pos == 4'd3 && $past(cap_pos) != 4'd3) |-> $past(form_err));

    a_r10_clear_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_clear && !form_err) |=> (cap_type == 3'b000 && cap_pos == 4'd15));

endmodule

bind can_ctrl_form_chk can_cfc_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .stuff_bit (stuff_bit),
    .frame_end (frame_end),
    .sw_clear  (sw_clear),
    .form_err  (frm_err),
    .err_req   (err_req),
    .cap_type  (cap_type),
    .cap_pos   (cap_pos)
);

// File: tb/can_ctrl_form_chk_test.sv
module can_ctrl_form_chk_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fd_en = 1'b0;
    logic       arb_start = 1'b0;
    logic       bit_vld = 1'b0;
    logic       bit_val = 1'b0;
    logic       stuff_bit = 1'b0;
    logic       frame_end = 1'b0;
    logic       sw_clear = 1'b0;
    logic       err_req;
    logic [2:0] cap_type;
    logic [3:0] cap_pos;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    can_ctrl_form_chk uut (
        .clk(clk), .rst_n(rst_n), .fd_en(fd_en), .arb_start(arb_start),
        .bit_vld(bit_vld), .bit_val(bit_val), .stuff_bit(stuff_bit),
        .frame_end(frame_end), .sw_clear(sw_clear), .err_req(err_req),
        .cap_type(cap_type), .cap_pos(cap_pos)
    );

    task automatic chk(input string tag, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic chk_out(input string tag, input logic e);
        chk({tag, " req"},  int'(err_req),  int'(e));
        chk({tag, " type"}, int'(cap_type), e ? 2 : 0);
        chk({tag, " pos"},  int'(cap_pos),  e ? 3 : 15);
    endtask

    // One cycle of strobes, driven at a falling edge, released at the next
    task automatic step(input logic a, input logic v, input logic b,
                        input logic s, input logic fe, input logic cl);
        arb_start = a; bit_vld = v; bit_val = b;
        stuff_bit = s; frame_end = fe; sw_clear = cl;
        @(negedge clk);
        arb_start = 0; bit_vld = 0; bit_val = 0;
        stuff_bit = 0; frame_end = 0; sw_clear = 0;
    endtask

    task automatic new_frame();
        step(0, 0, 0, 0, 1, 1);
    endtask

    // stuff_at / clr_with / clr_before: bit index or -1
    task automatic run_frame(input logic [39:0] fb, input int nbits,
                             input int stuff_at, input logic stuff_val,
                             input int clr_with, input int clr_before);
        step(1, 0, 0, 0, 0, 0);
        for (int k = 0; k < nbits; k++) begin
            if (k == stuff_at)   step(0, 1, stuff_val, 1, 0, 0);
            if (k == clr_before) step(0, 0, 0, 0, 0, 1);
            step(0, 1, fb[k], 0, 0, k == clr_with);
        end
    endtask

    // All reserved / format positions dominant
    function automatic logic [39:0] quiet(input logic ide);
        logic [39:0] f;
        f = 40'({$urandom(), $urandom()});
        f[12] = ide; f[13] = 0; f[14] = 0; f[32] = 0; f[33] = 0;
        return f;
    endfunction

    function automatic logic model(input logic [39:0] f, input logic fe);
        if (!f[12]) begin
            if (!fe) return f[13];
            return f[13] & f[14];
        end
        if (!fe) return f[32] | f[33];
        return f[33];
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got 0 expected 1 (run completed)");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [39:0] fb;
        logic        e;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_out("R1 reset", 1'b0);

        // R2 classic base r0
        fd_en = 0; fb = quiet(0); fb[13] = 1;
        new_frame(); run_frame(fb, 20, -1, 0, -1, -1);
        chk_out("R2 base r0", 1'b1);
        // R8 held across new arbitration start and more bits
        run_frame(quiet(0), 5, -1, 0, -1, -1);
        chk("R8 held", int'(err_req), 1);
        new_frame();
        chk_out("R8 R10 cleared by frame_end+sw_clear", 1'b0);

        // R3 FD base
        fd_en = 1; fb = quiet(0); fb[13] = 1; fb[14] = 1;
        new_frame(); run_frame(fb, 20, -1, 0, -1, -1);
        chk_out("R3 fd base r0", 1'b1);
        fb = quiet(0); fb[14] = 1;
        new_frame(); run_frame(fb, 20, -1, 0, -1, -1);
        chk_out("R3 classic layout offset14 unchecked", 1'b0);
        fb = quiet(0); fb[13] = 1;
        new_frame(); run_frame(fb, 20, -1, 0, -1, -1);
        chk_out("R3 fdf recessive alone", 1'b0);

        // R4 classic extended
        fd_en = 0; fb = quiet(1); fb[32] = 1;
        new_frame(); run_frame(fb, 36, -1, 0, -1, -1);
        chk_out("R4 ext r1", 1'b1);
        fb = quiet(1); fb[33] = 1;
        new_frame(); run_frame(fb, 36, -1, 0, -1, -1);
        chk_out("R4 ext r0", 1'b1);

        // R5 FD extended
        fd_en = 1; fb = quiet(1); fb[32] = 1; fb[33] = 1;
        new_frame(); run_frame(fb, 36, -1, 0, -1, -1);
        chk_out("R5 fd ext r0", 1'b1);
        fb = quiet(1); fb[32] = 1;
        new_frame(); run_frame(fb, 36, -1, 0, -1, -1);
        chk_out("R5 fdf bit no error", 1'b0);

        // R6 stuff strobes
        fd_en = 0; fb = quiet(0);
        new_frame(); run_frame(fb, 20, 13, 1'b1, -1, -1);
        chk_out("R6 recessive stuff at r0 slot", 1'b0);
        fb = quiet(0); fb[13] = 1;
        new_frame(); run_frame(fb, 20, 13, 1'b0, -1, -1);
        chk_out("R6 offset not advanced by stuff", 1'b1);

        // R7 recessive everywhere except reserved slots
        fd_en = 0; fb = 40'hFF_FFFF_FFFF; fb[13] = 0;
        new_frame(); run_frame(fb & ~40'h1000, 40, -1, 0, -1, -1);
        chk_out("R7 base non-reserved recessive", 1'b0);
        fb = 40'hFF_FFFF_FFFF; fb[32] = 0; fb[33] = 0;
        new_frame(); run_frame(fb, 40, -1, 0, -1, -1);
        chk_out("R7 ext non-reserved recessive", 1'b0);

        // R9 clear between two errors of one frame
        fd_en = 0; fb = quiet(1); fb[32] = 1; fb[33] = 1;
        new_frame(); run_frame(fb, 36, -1, 0, -1, 33);
        chk("R9 req", int'(err_req), 1);
        chk("R9 type unchanged", int'(cap_type), 0);
        chk("R9 pos unchanged", int'(cap_pos), 15);

        // R10 clear in same cycle as first error
        fb = quiet(0); fb[13] = 1;
        new_frame(); run_frame(fb, 20, -1, 0, 13, -1);
        chk_out("R10 error beats clear", 1'b1);

        // R11 strobes outside a frame
        new_frame();
        for (int k = 0; k < 40; k++) step(0, 1, 1, 0, 0, 0);
        chk_out("R11 no tracking after frame_end", 1'b0);

        // R7 random frames against model
        for (int n = 0; n < 300; n++) begin
            int nb, sa;
            fd_en = 1'($urandom() % 2);
            fb = 40'({$urandom(), $urandom()});
            fb[13] = ($urandom() % 10) < 3;
            fb[14] = ($urandom() % 10) < 3;
            fb[32] = ($urandom() % 10) < 3;
            fb[33] = ($urandom() % 10) < 3;
            nb = 34 + int'($urandom() % 6);
            sa = ($urandom() % 2) ? int'($urandom() % 34) : -1;
            e  = model(fb, fd_en);
            new_frame();
            run_frame(fb, nb, sa, 1'($urandom() % 2), -1, -1);
            chk_out("R7 random frame", e);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule